// File: doc/BRIEF.md
# Repeated String Output Engine

This block moves a run of bytes from memory to a single I/O port without processor involvement. Software loads a start offset, a 16-bit port address, a byte count and a direction bit, then pulses start. For each byte the engine fetches from memory at the current offset, waits for the memory to answer, and issues a one-cycle write of that byte to the fixed port. After each write the offset moves one step, up or down depending on the direction bit, and the remaining count drops by one.

The transfer ends when the count runs out. A count of zero at start moves nothing and finishes at once. While a transfer is running the block reports busy and ignores further start pulses. A single-cycle done pulse marks the end.

Top module: `str_out_engine`

## Requirements
- R1: While rst_ni is low, busy_o, done_o, mem_req_o and io_wr_o are all 0.
- R2: Each memory read is issued at the current source offset, and the byte written to the port equals the byte that memory returned for that read.
- R3: io_addr_o carries, on every write of a transfer, the port address sampled at start and does not change while busy_o is high.
- R4: With dir_dn_i = 0 at start the offset rises by one after each byte, and with dir_dn_i = 1 it falls by one. Both wrap modulo 2^ADDR_W.
- R5: A start with count N > 0 produces exactly N port writes before done_o. With CNT_W of at least 13, a count of 4096 moves 4096 bytes.
- R6: A start with count 0 raises done_o in the cycle after start, with no memory read and no port write.
- R7: A port write happens only in the cycle after a memory read was accepted (mem_req_o and mem_valid_i both high). io_wr_o is never high on two consecutive cycles.
- R8: busy_o is high from the cycle after start through the done_o cycle. done_o lasts one cycle, and busy_o is low in the next cycle.
- R9: A start pulse while busy_o is high has no effect on the running transfer's writes, addresses or length.
- R10: Once mem_req_o is raised, it stays high with a stable mem_addr_o until mem_valid_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only when idle |
| src_off_i | input | ADDR_W | First memory offset |
| port_addr_i | input | PORT_W | Destination port address |
| count_i | input | CNT_W | Number of bytes to move |
| dir_dn_i | input | 1 | 1: offset falls per byte, 0: offset rises |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read offset |
| mem_valid_i | input | 1 | Memory read data valid |
| mem_data_i | input | DATA_W | Memory read data |
| io_wr_o | output | 1 | One-cycle port write strobe |
| io_addr_o | output | PORT_W | Port address |
| io_data_o | output | DATA_W | Port write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench builds the engine with ADDR_W = 8 and CNT_W = 13, keeping PORT_W = 16 and DATA_W = 8. The 8-bit offset lets short runs started near 0 or 255 cross the wrap point in both directions. A 4096-byte run walks the whole offset space sixteen times and uses the full count width. Every count from 0 to 24 is swept in both directions, with memory latencies of 0 to 3 cycles. Expected bytes come from an arithmetic memory pattern computed in the bench.

// File: rtl/str_out_pkg.sv
package str_out_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } str_state_e;
endpackage

// File: rtl/str_ptr_unit.sv
module str_ptr_unit #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic              dir_dn_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              dir_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr_q;
  logic              dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      dir_q <= 1'b0;
    end else if (load_i) begin
      ptr_q <= off_i;
      dir_q <= dir_dn_i;
    end else if (step_i) begin
      ptr_q <= dir_q ? ptr_q - ONE : ptr_q + ONE;
    end
  end

  assign ptr_o = ptr_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/str_cnt_unit.sv
module str_cnt_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= cnt_i;
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  // the write that takes the count from one to zero ends the run
  assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/str_ctrl.sv
module str_ctrl
  import str_out_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic start_zero_i,
  input  logic last_i,
  input  logic mem_valid_i,
  output logic load_o,
  output logic capture_o,
  output logic step_o,
  output logic mem_req_o,
  output logic busy_o,
  output logic done_o
);
  str_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    load_o    = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o  = 1'b1;
        state_d = start_zero_i ? ST_FIN : ST_READ;
      end
      ST_READ: if (mem_valid_i) begin
        capture_o = 1'b1;
        state_d   = ST_WRITE;
      end
      ST_WRITE: state_d = last_i ? ST_FIN : ST_READ;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign step_o    = (state_q == ST_WRITE);
  assign mem_req_o = (state_q == ST_READ);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FIN);
endmodule

// File: rtl/str_out_engine.sv
module str_out_engine #(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_off_i,
  input  logic [PORT_W-1:0] port_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              dir_dn_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              io_wr_o,
  output logic [PORT_W-1:0] io_addr_o,
  output logic [DATA_W-1:0] io_data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              load, capture, step, last, dir_q;
  logic [PORT_W-1:0] port_q;
  logic [DATA_W-1:0] data_q;

  str_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_zero_i(count_i == '0),
    .last_i      (last),
    .mem_valid_i (mem_valid_i),
    .load_o      (load),
    .capture_o   (capture),
    .step_o      (step),
    .mem_req_o   (mem_req_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  str_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .off_i   (src_off_i),
    .dir_dn_i(dir_dn_i),
    .step_i  (step),
    .ptr_o   (mem_addr_o),
    .dir_o   (dir_q)
  );

  str_cnt_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .cnt_i (count_i),
    .dec_i (step),
    .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q <= '0;
      data_q <= '0;
    end else begin
      if (load)    port_q <= port_addr_i;
      if (capture) data_q <= mem_data_i;
    end
  end

  assign io_wr_o   = step;
  assign io_addr_o = port_q;
  assign io_data_o = data_q;
endmodule

// File: rtl/str_out_chk.sv
module str_out_chk #(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_valid_i,
  input logic              io_wr_o,
  input logic [PORT_W-1:0] io_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              dir_q
);
  logic [ADDR_W-1:0] prev_addr;
  logic              have_prev;
  logic              accept;

  assign accept = mem_req_o && mem_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else if (!busy_o || done_o) begin
      have_prev <= 1'b0;
    end else if (accept) begin
      prev_addr <= mem_addr_o;
      have_prev <= 1'b1;
    end
  end

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && have_prev) |->
      (mem_addr_o == (dir_q ? prev_addr - ADDR_W'(1) : prev_addr + ADDR_W'(1))));

  assert_wr_after_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> io_wr_o);

  assert_wr_needs_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !io_wr_o);

  assert_wr_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_o |=> !io_wr_o);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_port_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(io_addr_o));

  assert_done_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o ##1 !busy_o));

  assert_zero_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && count_i == '0) |=> (done_o && !mem_req_o && !io_wr_o));

  assert_start_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
endmodule

bind str_out_engine str_out_chk #(
  .ADDR_W(ADDR_W),
  .PORT_W(PORT_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .count_i    (count_i),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_valid_i(mem_valid_i),
  .io_wr_o    (io_wr_o),
  .io_addr_o  (io_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .dir_q      (dir_q)
);

// File: tb/str_out_engine_tb.sv
module str_out_engine_tb;
  localparam int AW = 8;
  localparam int PW = 16;
  localparam int CW = 13;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] src_off_i = '0;
  logic [PW-1:0] port_addr_i = '0;
  logic [CW-1:0] count_i = '0;
  logic          dir_dn_i = 1'b0;
  logic          mem_valid_i = 1'b0;
  logic [DW-1:0] mem_data_i = '0;
  logic          mem_req_o, io_wr_o, busy_o, done_o;
  logic [AW-1:0] mem_addr_o;
  logic [PW-1:0] io_addr_o;
  logic [DW-1:0] io_data_o;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int wcnt = 0;
  int last_nw = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  str_out_engine #(.ADDR_W(AW), .PORT_W(PW), .CNT_W(CW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .src_off_i(src_off_i),
    .port_addr_i(port_addr_i), .count_i(count_i), .dir_dn_i(dir_dn_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i),
    .mem_data_i(mem_data_i), .io_wr_o(io_wr_o), .io_addr_o(io_addr_o),
    .io_data_o(io_data_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    pat = 8'((int'(a) * 37 + 5) & 255);
  endfunction

  // memory answers lat cycles after a request appears
  always @(posedge clk) begin
    #2;
    if (mem_req_o && !mem_valid_i) begin
      if (wcnt >= lat) begin
        mem_valid_i = 1'b1;
        mem_data_i  = pat(mem_addr_o);
      end else begin
        wcnt++;
      end
    end else begin
      mem_valid_i = 1'b0;
      wcnt = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [AW-1:0] off, input logic [PW-1:0] port,
                          input logic [CW-1:0] n, input bit dir, input int l, input bit poke);
    logic [AW-1:0] exp_ptr;
    int nw, cyc;
    bit prev_acc, prev_wr, got_done, busy_ok, ord_ok, addr_ok, data_ok, port_ok, ptr_ok;
    @(negedge clk);
    src_off_i = off; port_addr_i = port; count_i = n; dir_dn_i = dir; lat = l;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    exp_ptr = off; nw = 0; cyc = 0; prev_acc = 0; prev_wr = 0; got_done = 0;
    busy_ok = 1; ord_ok = 1; addr_ok = 1; data_ok = 1; port_ok = 1; ptr_ok = 1;
    if (n == 0) begin
      check(done_o && !mem_req_o && !io_wr_o, "R6 zero count done", {done_o, mem_req_o, io_wr_o}, 3'b100);
      @(negedge clk);
      check(!busy_o && !done_o, "R8 idle after zero run", {busy_o, done_o}, 2'b00);
      last_nw = 0;
      return;
    end
    while (!got_done && cyc < 40000) begin
      if (start_i) start_i = 1'b0;
      if (!busy_o) busy_ok = 0;
      if (mem_req_o && mem_addr_o != exp_ptr) ptr_ok = 0;
      if (io_wr_o) begin
        if (!prev_acc || prev_wr) ord_ok = 0;
        if (io_addr_o != port) port_ok = 0;
        if (io_data_o != pat(exp_ptr)) data_ok = 0;
        exp_ptr = dir ? exp_ptr - AW'(1) : exp_ptr + AW'(1);
        nw++;
        if (poke && nw == 1) begin
          start_i = 1'b1; src_off_i = ~off; port_addr_i = ~port; count_i = 3; dir_dn_i = ~dir;
        end
      end
      if (done_o) got_done = 1;
      prev_acc = mem_req_o && mem_valid_i;
      prev_wr  = io_wr_o;
      cyc++;
      @(negedge clk);
    end
    check(got_done, "R5 run ended", got_done, 1);
    check(nw == int'(n), "R5 write count", nw, n);
    check(data_ok, "R2 byte matches memory at offset", data_ok, 1);
    check(ptr_ok, dir ? "R4 offset falls" : "R4 offset rises", ptr_ok, 1);
    check(port_ok, "R3 port address fixed", port_ok, 1);
    check(ord_ok, "R7 write follows accepted read", ord_ok, 1);
    check(busy_ok, "R8 busy through run", busy_ok, 1);
    check(!busy_o, "R8 busy low after done", busy_o, 0);
    last_nw = nw;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(!busy_o && !done_o && !mem_req_o && !io_wr_o, "R1 reset outputs",
          {busy_o, done_o, mem_req_o, io_wr_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o, "R1 idle after reset", {busy_o, done_o}, 0);

    for (int d = 0; d < 2; d++) begin
      for (int n = 0; n <= 24; n++) begin
        run_xfer(AW'((n * 29 + d * 101 + 240) & 255), PW'(16'hA500 ^ (n * 16'h0111)),
                 CW'(n), d[0], n % 4, 1'b0);
      end
    end
    // wrap at the ends of the offset space
    run_xfer(8'hFD, 16'h1234, 6, 1'b0, 1, 1'b0);
    run_xfer(8'h02, 16'hFFFF, 6, 1'b1, 2, 1'b0);
    // start pulse while busy
    run_xfer(8'h40, 16'h0F0F, 9, 1'b0, 1, 1'b1);
    check(last_nw == 9, "R9 start while busy ignored", last_nw, 9);
    run_xfer(8'h80, 16'h3C3C, 7, 1'b1, 0, 1'b1);
    check(last_nw == 7, "R9 start while busy ignored down", last_nw, 7);
    // full 4K block
    run_xfer(8'h10, 16'h0047, 13'h1000, 1'b0, 0, 1'b0);
    check(last_nw == 4096, "R5 4096 byte block", last_nw, 4096);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule